// File: doc/BRIEF.md
# Mailbox Barrier Synchroniser

This block holds a group of N processors at a common synchronisation point. Each processor has its own mailbox, a small token counter indexed by the processor's port number. When a processor announces that it has arrived, the unit puts one token into the mailbox of every other processor and none into its own. The arriving processor is then held until its own mailbox contains N-1 tokens. Every other processor must have arrived to supply those tokens, so nobody passes until the whole group is present.

Each processor lane runs a three-state controller. `ST_IDLE` waits for an arrival. `IDLE->WAIT` is taken on an arrival pulse, and the tokens are posted in that same cycle. `WAIT->WAIT` holds while the mailbox has fewer than N-1 tokens. `WAIT->RELEASE` is taken once N-1 tokens are present, and those tokens are removed on that transition. `ST_RELEASE` drives the release pulse for one cycle. From there, `RELEASE->WAIT` is taken if a new arrival comes in that cycle (the tokens are posted), and `RELEASE->IDLE` is taken otherwise.

When several arrivals land in the same cycle, all of their posts are added into each mailbox together. Tokens that arrive for a processor still sitting in `ST_IDLE` stay in its mailbox. This lets a fast processor enter the next barrier early without losing its tokens.

Top module: `barrier_unit`

## Requirements
- R1: After reset every release output is 0, every mailbox holds 0 tokens and every lane is in `ST_IDLE`.
- R2: An arrival accepted on lane p adds exactly one token to every mailbox except mailbox p.
- R3: A lane is never released while its mailbox holds fewer than N-1 tokens, so no lane is released before all N lanes have arrived for that barrier.
- R4: The release for lane p is high for exactly one cycle. It shows in the second cycle after the cycle in which the last missing arrival was presented, which means two clock edges later.
- R5: N-1 tokens are subtracted from a mailbox on its release transition. Any extra tokens stay queued for the next barrier.
- R6: Arrivals presented in the same cycle on several lanes are all accepted, and their tokens are summed into each mailbox.
- R7: An arrival presented while a lane is in `ST_WAIT` is ignored and posts no tokens.
- R8: An arrival presented in the cycle where the lane's release is high is accepted and starts the next barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| arrive_i | input | NUM_PROCS | One-cycle arrival request per processor; bit p is processor p |
| release_o | output | NUM_PROCS | One-cycle release pulse per processor |

## Verification
A mailbox count that is too high shows up as a release that comes early. It appears two edges after the arrival that was not the last one, or in the following barrier if extra tokens were posted by an ignored arrival. A count that is too low, or a lane stuck in `ST_WAIT`, shows up as a release that is missing two edges after the final arrival. A release pulse that does not return to idle shows up one cycle later as a second high cycle. The directed scenarios run back-to-back barriers so that queued or leaked tokens are caught within the next barrier.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT    = 2'd1,
        ST_RELEASE = 2'd2
    } bar_state_e;
endpackage

// File: rtl/barrier_post_router.sv
// Turns the per-lane post strobes into a token increment for each mailbox.
// A lane never counts towards its own mailbox.
module barrier_post_router #(
    parameter int NUM_PROCS = 4,
    parameter int CNT_W     = 3
) (
    input  logic [NUM_PROCS-1:0]            post_i,
    output logic [NUM_PROCS-1:0][CNT_W-1:0] inc_o
);
    for (genvar m = 0; m < NUM_PROCS; m++) begin : g_box
        always_comb begin
            inc_o[m] = '0;
            for (int s = 0; s < NUM_PROCS; s++) begin
                if (s != m && post_i[s]) begin
                    inc_o[m] = inc_o[m] + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/barrier_mailbox.sv
// Token counter for one processor.
module barrier_mailbox #(
    parameter int NUM_PROCS = 4,
    parameter int CNT_W     = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] inc_i,
    input  logic             consume_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] NEED = CNT_W'(NUM_PROCS - 1);
    localparam logic [CNT_W:0]   MAXV = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] count_q, count_d;
    logic             hist_ok_q;

    always_comb begin
        count_d = count_q + inc_i - (consume_i ? NEED : '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q   <= '0;
            hist_ok_q <= 1'b0;
        end else begin
            count_q   <= count_d;
            hist_ok_q <= 1'b1;
        end
    end

    assign count_o = count_q;

    logic [CNT_W:0] sum_w;
    assign sum_w = {1'b0, count_q} + {1'b0, inc_i};

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sum_w <= MAXV); // R5
    AST_CONSUME_ENOUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        consume_i |-> (count_q >= NEED)); // R3
    AST_COUNT_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hist_ok_q |-> (count_q == $past(count_q) + $past(inc_i)
                                   - ($past(consume_i) ? NEED : '0))); // R6
endmodule

// File: rtl/barrier_fsm.sv
// Controller for one processor lane: idle, waiting for tokens, release pulse.
module barrier_fsm
    import barrier_pkg::*;
#(
    parameter int NUM_PROCS = 4,
    parameter int CNT_W     = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arrive_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             post_o,
    output logic             consume_o,
    output logic             release_o
);
    localparam logic [CNT_W-1:0] NEED = CNT_W'(NUM_PROCS - 1);

    bar_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (arrive_i) state_d = ST_WAIT;
            ST_WAIT:    if (count_i >= NEED) state_d = ST_RELEASE;
            ST_RELEASE: state_d = arrive_i ? ST_WAIT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        post_o    = 1'b0;
        consume_o = 1'b0;
        release_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    post_o = arrive_i;
            ST_WAIT:    consume_o = (count_i >= NEED);
            ST_RELEASE: begin
                release_o = 1'b1;
                post_o    = arrive_i;
            end
            default: ;
        endcase
    end

    AST_REL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        release_o |=> !release_o); // R4
    AST_REL_AFTER_CONSUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(release_o) |-> $past(consume_o)); // R3
    AST_POST_ENTERS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        post_o |=> (state_q == ST_WAIT)); // R2
    AST_WAIT_NO_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WAIT) |-> !post_o); // R7
endmodule

// File: rtl/barrier_unit.sv
module barrier_unit #(
    parameter int NUM_PROCS = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PROCS-1:0] arrive_i,
    output logic [NUM_PROCS-1:0] release_o
);
    localparam int CNT_W = $clog2(NUM_PROCS) + 1;

    if (NUM_PROCS < 2) begin : g_bad_param
        $error("barrier_unit needs at least two processors");
    end

    logic [NUM_PROCS-1:0]            post_w;
    logic [NUM_PROCS-1:0]            consume_w;
    logic [NUM_PROCS-1:0][CNT_W-1:0] inc_w;
    logic [NUM_PROCS-1:0][CNT_W-1:0] count_w;

    barrier_post_router #(.NUM_PROCS(NUM_PROCS), .CNT_W(CNT_W)) router_i (
        .post_i (post_w),
        .inc_o  (inc_w)
    );

    for (genvar p = 0; p < NUM_PROCS; p++) begin : g_lane
        barrier_fsm #(.NUM_PROCS(NUM_PROCS), .CNT_W(CNT_W)) fsm_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .arrive_i  (arrive_i[p]),
            .count_i   (count_w[p]),
            .post_o    (post_w[p]),
            .consume_o (consume_w[p]),
            .release_o (release_o[p])
        );
        barrier_mailbox #(.NUM_PROCS(NUM_PROCS), .CNT_W(CNT_W)) box_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .inc_i     (inc_w[p]),
            .consume_i (consume_w[p]),
            .count_o   (count_w[p])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (release_o == '0)); // R1
endmodule

// File: tb/barrier_unit_tb_top.sv
module barrier_unit_tb_top;
    localparam int N = 4;
    localparam logic [N-1:0] ALL = '1;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [N-1:0] arrive_i = '0;
    logic [N-1:0] release_o;

    int checks = 0;
    int errors = 0;

    always #4 clk_i = ~clk_i;

    barrier_unit #(.NUM_PROCS(N)) dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arrive_i  (arrive_i),
        .release_o (release_o)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: release_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Present arrivals a across one edge; rel is release_o after that edge.
    task automatic tick(input logic [N-1:0] a, output logic [N-1:0] rel);
        arrive_i = a;
        @(negedge clk_i);
        arrive_i = '0;
        rel = release_o;
    endtask

    task automatic t_reset();
        logic [N-1:0] r;
        chk("R1 reset", release_o, '0);
        for (int i = 0; i < 4; i++) begin
            tick('0, r);
            chk("R1 idle after reset", r, '0);
        end
    endtask

    task automatic t_simultaneous();
        logic [N-1:0] r;
        tick(ALL, r); chk("R6 all arrive, held one cycle", r, '0);
        tick('0, r);  chk("R6 R4 summed posts release all", r, ALL);
        tick('0, r);  chk("R4 single-cycle pulse", r, '0);
    endtask

    task automatic t_staggered();
        logic [N-1:0] r;
        tick(4'b0001, r); chk("R3 only lane0 arrived", r, '0);
        tick('0, r);      chk("R3 lane0 held", r, '0);
        tick(4'b0010, r); chk("R2 lane1 arrived", r, '0);
        tick(4'b0100, r); chk("R2 lane2 arrived", r, '0);
        tick('0, r);      chk("R3 three of four arrived", r, '0);
        tick(4'b1000, r); chk("R4 last arrival edge", r, '0);
        tick('0, r);      chk("R4 release two edges after last", r, ALL);
        tick('0, r);      chk("R4 pulse ends", r, '0);
    endtask

    task automatic t_partial();
        logic [N-1:0] r;
        tick(4'b0111, r);
        for (int i = 0; i < 10; i++) begin
            tick('0, r);
            chk("R3 missing lane3 blocks all", r, '0);
        end
        tick(4'b1000, r); chk("R3 lane3 arrival edge", r, '0);
        tick('0, r);      chk("R3 all released", r, ALL);
        tick('0, r);      chk("R4 pulse ends", r, '0);
    endtask

    task automatic t_ignore_wait();
        logic [N-1:0] r;
        tick(4'b0001, r);
        tick(4'b0001, r); chk("R7 repeat arrival while waiting", r, '0);
        tick(4'b0001, r); chk("R7 repeat arrival while waiting", r, '0);
        tick(4'b1110, r); chk("R7 others arrive", r, '0);
        tick('0, r);      chk("R7 release", r, ALL);
        tick('0, r);
        // Extra posts from lane0 would now release lanes 1..3 early.
        tick(4'b1110, r); chk("R7 next barrier without lane0", r, '0);
        for (int i = 0; i < 5; i++) begin
            tick('0, r);
            chk("R7 no leaked tokens", r, '0);
        end
        tick(4'b0001, r); chk("R7 lane0 arrival edge", r, '0);
        tick('0, r);      chk("R7 all released", r, ALL);
        tick('0, r);
    endtask

    task automatic t_back_to_back();
        logic [N-1:0] r;
        tick(ALL, r);
        tick('0, r);      chk("R5 first barrier release", r, ALL);
        // Lane0 arrives in its release cycle.
        tick(4'b0001, r); chk("R8 early re-arrival held", r, '0);
        for (int i = 0; i < 3; i++) begin
            tick('0, r);
            chk("R5 lane0 waits for others", r, '0);
        end
        tick(4'b0010, r); chk("R5 lane1 uses queued token", r, '0);
        tick(4'b0100, r); chk("R5 lane2 arrives", r, '0);
        tick(4'b1000, r); chk("R5 lane3 arrival edge", r, '0);
        tick('0, r);      chk("R5 R8 second barrier release", r, ALL);
        tick('0, r);      chk("R4 pulse ends", r, '0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: release_o=%b expected run to complete", release_o);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_simultaneous();
        t_staggered();
        t_partial();
        t_ignore_wait();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule